// File: doc/BRIEF.md
# Dual H-Bridge Complementary PWM Generator

This block produces the switching signals for two brushed DC motors, each driven through an H-bridge. One up-counter is shared by both motors. It counts from zero to one below the period length and then wraps, so every PWM edge is aligned to the start of the period. Each motor takes a signed speed command. The command is saturated to the range -1.0 to +1.0 and turned into a compare value. The compare value sets how long the high-true output of that motor stays high in each period. The second output of each pair is the exact complement of the first.

A command of zero gives a 50% duty cycle, which applies no net voltage across the bridge. Full positive and full negative commands hold the pair fully on or fully off. New compare values take effect only when the counter wraps. Because of this, a command that changes in the middle of a period never yields a partial or torn pulse.

The block has no state machine. It is built from a free-running timebase, a combinational mapper from command to compare value, and one registered compare stage per motor. All four are plain datapath logic, and none has named states or transitions.

Top module: `dual_hbridge_pwm`

## Requirements
- R1: The shared counter steps by one on every clock from 0 up to PERIOD-1 and then returns to 0. PERIOD defaults to CLK_HZ/PWM_HZ, which is 25000 for a 100 MHz clock at a 4 kHz switching rate.
- R2: Each command is a 16-bit two's-complement value with 14 fraction bits, so 16384 represents +1.0. A command above +16384 is treated as +16384, and a command below -16384 is treated as -16384.
- R3: For a saturated command c, the compare value is floor(PERIOD*(c+16384)/32768). The high-true output of the motor is 1 exactly while the counter is below the compare value, so it is high for that many cycles in each period.
- R4: A command of zero gives floor(PERIOD/2) high cycles per period. A command of +1.0 keeps the high-true output high for the whole period, and -1.0 keeps it low for the whole period.
- R5: In every cycle, the inverted output of each motor is the complement of that motor's high-true output.
- R6: The output bits are assigned as follows: ch[2] is the high-true output of motor A, ch[3] is the inverted output of motor A, ch[0] is the high-true output of motor B, and ch[1] is the inverted output of motor B.
- R7: A motor's compare value is loaded only in the cycle where the counter is at PERIOD-1. A command change partway through a period first affects the period that follows.
- R8: During reset and after it, the counter is 0 and both compare values hold the zero-command value. While reset is held, ch[2] and ch[0] are 1, and ch[3] and ch[1] are 0.
- R9: The command of one motor has no effect on the outputs of the other motor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_a | input | 16 | Signed speed command for motor A (Q1.14) |
| cmd_b | input | 16 | Signed speed command for motor B (Q1.14) |
| ch | output | 4 | PWM outputs: [3:2] motor A inverted/true, [1:0] motor B inverted/true |

## Verification
The hardest case to reach from the ports is a command that changes partway through a period. If the design loaded compare values immediately instead of at the wrap, the result would still look like a valid duty cycle a period later, so the error would be hidden. The bench first finds the start of a period by watching for the rising edge of ch[2]. It counts ten cycles into the period and then changes the command. It then counts the high cycles up to the end of that same period and expects the old duty. A following window of one full period must show the new duty.

// File: rtl/dhp_pkg.sv
package dhp_pkg;
    localparam int CMD_W    = 16;
    localparam int FRAC_W   = 14;
    localparam int UNIT     = 1 << FRAC_W;         // +1.0 in Q1.14
    localparam int SPAN_SH  = FRAC_W + 1;          // divide by 2*UNIT

    typedef logic signed [CMD_W-1:0] speed_cmd_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int PERIOD = 25000,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // R1: count stays inside the period
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R1: wrap returns to zero
    a_r1_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));

    // R1: otherwise count advances by one
    a_r1_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/pwm_duty_map.sv
module pwm_duty_map
    import dhp_pkg::*;
#(
    parameter int PERIOD = 25000,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  speed_cmd_t    cmd,
    output logic [CW-1:0] cmp
);
    localparam int PW = CW + CMD_W + 1;
    localparam speed_cmd_t POS_LIM = speed_cmd_t'(UNIT);
    localparam speed_cmd_t NEG_LIM = speed_cmd_t'(-UNIT);

    speed_cmd_t           sat;
    logic [CMD_W-1:0]     offs;
    logic [PW-1:0]        prod;

    always_comb begin
        if (cmd > POS_LIM)
            sat = POS_LIM;
        else if (cmd < NEG_LIM)
            sat = NEG_LIM;
        else
            sat = cmd;
        offs = CMD_W'(sat + POS_LIM);              // 0 .. 2*UNIT
        prod = PW'(PERIOD) * PW'(offs);
        cmp  = CW'(prod >> SPAN_SH);
    end

    // R2: saturated command stays within +/-1.0
    always_comb begin
        a_r2_sat_range: assert (sat <= POS_LIM && sat >= NEG_LIM);
    end
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out #(
    parameter int PERIOD = 25000,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp_next,
    output logic          out_true,
    output logic          out_inv
);
    localparam logic [CW-1:0] MID = CW'(PERIOD / 2);

    logic [CW-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmp_q <= MID;
        else if (wrap)
            cmp_q <= cmp_next;
    end

    assign out_true = (cnt < cmp_q);
    assign out_inv  = ~out_true;

    // R7: compare value holds between wraps
    a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cmp_q));

    // R3: compare value never exceeds the period
    a_r3_cmp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_q <= CW'(PERIOD));
endmodule

// File: rtl/dual_hbridge_pwm.sv
module dual_hbridge_pwm
    import dhp_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int PWM_HZ = 4000,
    parameter int PERIOD = CLK_HZ / PWM_HZ
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cmd_a,
    input  logic [15:0] cmd_b,
    output logic [3:0]  ch
);
    localparam int CW     = $clog2(PERIOD + 1);
    localparam int MOTORS = 2;

    logic [CW-1:0] cnt;
    logic          wrap;
    speed_cmd_t    cmds    [MOTORS];
    logic [1:0]    pair_ch [MOTORS];   // [1]=inverted, [0]=true

    pwm_timebase #(.PERIOD(PERIOD), .CW(CW)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .wrap (wrap)
    );

    // index 0 = motor B (ch[1:0]), index 1 = motor A (ch[3:2])
    assign cmds[0] = speed_cmd_t'(cmd_b);
    assign cmds[1] = speed_cmd_t'(cmd_a);

    for (genvar m = 0; m < MOTORS; m++) begin : g_motor
        logic [CW-1:0] cmp_next;

        pwm_duty_map #(.PERIOD(PERIOD), .CW(CW)) u_map (
            .cmd(cmds[m]),
            .cmp(cmp_next)
        );

        pwm_pair_out #(.PERIOD(PERIOD), .CW(CW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .wrap    (wrap),
            .cnt     (cnt),
            .cmp_next(cmp_next),
            .out_true(pair_ch[m][0]),
            .out_inv (pair_ch[m][1])
        );

        assign ch[2*m +: 2] = pair_ch[m];
    end

    // R8: at the first count after reset both true outputs are high
    a_r8_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ch[2] && ch[0]));
endmodule

// File: tb/dual_hbridge_pwm_tb.sv
`timescale 1ns/1ps
module dual_hbridge_pwm_tb;
    localparam int PERIOD = 100;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cmd_a = 16'd0;
    logic [15:0] cmd_b = 16'd0;
    logic [3:0]  ch;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_hbridge_pwm #(.PERIOD(PERIOD)) u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd_a(cmd_a),
        .cmd_b(cmd_b),
        .ch   (ch)
    );

    function automatic int exp_cmp(int c);
        int s;
        s = (c > 16384) ? 16384 : ((c < -16384) ? -16384 : c);
        return (PERIOD * (s + 16384)) / 32768;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // settle two periods, then count highs over one full period
    task automatic measure(string req, int ea, int eb);
        int ha = 0, hb = 0, bad = 0;
        repeat (2 * PERIOD) @(negedge clk);
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            ha += ch[2];
            hb += ch[0];
            if (ch[3] != ~ch[2] || ch[1] != ~ch[0]) bad++;
        end
        check({req, " motor A high cycles"}, ha, ea);
        check({req, " motor B high cycles"}, hb, eb);
        check({req, " R5 complement mismatches"}, bad, 0);
    endtask

    task automatic set_cmds(int a, int b);
        @(negedge clk);
        cmd_a = 16'(a);
        cmd_b = 16'(b);
    endtask

    task automatic t_reset;
        // R8: outputs while reset is held
        @(negedge clk);
        check("R8 ch during reset", int'(ch), 4'b0101);
        @(negedge clk);
        rst_n = 1;
        measure("R8 R4 zero after reset", PERIOD / 2, PERIOD / 2);
    endtask

    task automatic t_full_scale;
        set_cmds(16384, -16384);
        measure("R4 full scale", PERIOD, 0);
        set_cmds(-16384, 16384);
        measure("R4 R6 full scale swapped", 0, PERIOD);
    endtask

    task automatic t_saturate;
        set_cmds(32767, -32768);
        measure("R2 saturation", PERIOD, 0);
        set_cmds(20000, -17000);
        measure("R2 saturation near", PERIOD, 0);
    endtask

    task automatic t_mid_values;
        set_cmds(8192, -8192);
        measure("R3 half values", exp_cmp(8192), exp_cmp(-8192));
        set_cmds(1000, -12345);
        measure("R3 odd values", exp_cmp(1000), exp_cmp(-12345));
    endtask

    task automatic t_independent;
        // R9: change only A, B must stay at its value
        set_cmds(0, 4096);
        measure("R9 base", PERIOD / 2, exp_cmp(4096));
        set_cmds(-16000, 4096);
        measure("R9 A moved", exp_cmp(-16000), exp_cmp(4096));
    endtask

    task automatic t_commit_at_wrap;
        int prev = 1, h = 0;
        set_cmds(0, 0);
        repeat (2 * PERIOD) @(negedge clk);
        // find period start: rising edge of ch[2]
        forever begin
            @(negedge clk);
            if (ch[2] && !prev) break;
            prev = ch[2];
        end
        h = 1;
        for (int i = 1; i < PERIOD; i++) begin
            if (i == 10) begin
                cmd_a = 16'(8192);
            end
            @(negedge clk);
            h += ch[2];
        end
        check("R7 period with mid change keeps old duty", h, PERIOD / 2);
        h = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            h += ch[2];
        end
        check("R7 next period uses new duty", h, exp_cmp(8192));
    endtask

    initial begin
        t_reset();
        t_full_scale();
        t_saturate();
        t_mid_values();
        t_independent();
        t_commit_at_wrap();
        done = 1;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule